// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block sits on the host side of a four-wire serial flash link and carries out one complete erase on each start pulse. It can erase either one sector or the whole array. On a start it stores the erase type and the target address. It then runs three kinds of transaction in a fixed order. First it sends a write-enable command. Next it sends the erase command. Last it reads the status register again and again until the device reports that its self-timed erase has ended.

It reports the result on one of two single-cycle pulses. `done` means the erase finished. `timeout` means the device still reported busy after a programmable number of status reads. The serial clock comes from dividing the system clock. The link runs in mode 0: the clock idles low, the host sends its data while the clock is low, and it samples on the rising edge. Between any two transactions, chip select stays high for at least one full serial clock period. This is what lets the device start its erase cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `timeout` are 0.
- R2: Every erase starts with a write-enable transaction: opcode 0x06, 8 serial clocks, bits sent most significant first.
- R3: When `bulk_sel`=0, the second transaction is a sector erase. It sends opcode 0xD8 and then the 24-bit address captured at start, MSB first, for 32 serial clocks in total.
- R4: When `bulk_sel`=1, the second transaction is a bulk erase. It sends opcode 0xC7 only, for 8 serial clocks, with no address.
- R5: After the erase command, the block sends status reads. Each read is opcode 0x05 followed by 8 clocks, 16 clocks in all. During the last 8 clocks the block samples `spi_miso` MSB first. Status bit 0 is write-in-progress and bit 1 is the write-enable latch. The block repeats the read for as long as bit 0 is 1.
- R6: The first status read with bit 0 equal to 0 ends the job. `done` goes high for exactly one cycle, `busy` falls, and no further transaction follows.
- R7: Let L be the value of `poll_limit` captured at start. After max(L,1) consecutive status reads with bit 0 equal to 1, `timeout` goes high for one cycle instead of `done`, and no further transaction follows. `done` and `timeout` are never high together.
- R8: Between consecutive transactions, `spi_cs_n` stays high for at least 2*CLK_HALF system clock cycles.
- R9: The link runs in mode 0. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` changes only while `spi_sck` is low.
- R10: A `start` pulse that arrives while `busy` is 1 is ignored. It does not change the address, the erase type or the transaction sequence.
- R11: Each serial clock high phase lasts exactly CLK_HALF system clock cycles, so the serial clock period is 2*CLK_HALF cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request to begin an erase; ignored while busy |
| bulk_sel | input | 1 | 1 selects bulk (whole-array) erase, 0 selects sector erase |
| addr | input | 24 | Any address inside the sector to erase |
| poll_limit | input | POLL_W | Maximum number of busy status reads before timeout (0 acts as 1) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | High from an accepted start until done or timeout |
| done | output | 1 | One-cycle pulse when the erase has completed |
| timeout | output | 1 | One-cycle pulse when the poll limit is reached with the flash still busy |

## Verification
The assertions assume that `start` is a one-cycle pulse and that `spi_miso` is stable around each rising edge of `spi_sck`. The bench's flash model meets the second condition because it changes `spi_miso` only on falling serial clock edges. The stimulus holds `addr`, `bulk_sel` and `poll_limit` steady while it pulses `start`. It also sends extra start pulses with different values while the block is busy. The model's busy time is drawn both below and at or above the poll limit, and a limit of zero is included, so both endings are exercised.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int TX_W = 32;
  localparam int NB_W = 6;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SECT  = 8'hD8;
  localparam logic [7:0] OP_BULK  = 8'hC7;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam int         WIP_BIT  = 0;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_t;
  typedef enum logic [1:0] {C_IDLE, C_WREN, C_ERASE, C_POLL} c_state_t;
endpackage

// File: rtl/fes_rst_sync.sv
module fes_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fes_clk_div.sv
module fes_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/fes_shifter.sv
module fes_shifter
  import fes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic [TX_W-1:0]   tx_data,
  input  logic [NB_W-1:0]   nbits,
  input  logic              miso,
  output logic              run,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  output logic [7:0]        rx_byte,
  output logic              xfer_done
);
  sh_state_t        st_q, st_n;
  logic [TX_W-1:0]  sreg_q, sreg_n;
  logic [NB_W-1:0]  nb_q, nb_n;
  logic [NB_W-1:0]  bit_q, bit_n;
  logic [7:0]       rx_q, rx_n;
  logic             cs_q, cs_n_nx;
  logic             sck_q, sck_n;
  logic             mosi_q, mosi_n;
  logic             gap_q, gap_n;
  logic             dn_q, dn_n;

  always_comb begin
    st_n    = st_q;
    sreg_n  = sreg_q;
    nb_n    = nb_q;
    bit_n   = bit_q;
    rx_n    = rx_q;
    cs_n_nx = cs_q;
    sck_n   = sck_q;
    mosi_n  = mosi_q;
    gap_n   = gap_q;
    dn_n    = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (go) begin
          st_n    = SH_SHIFT;
          sreg_n  = tx_data;
          nb_n    = nbits;
          bit_n   = '0;
          cs_n_nx = 1'b0;
          sck_n   = 1'b0;
          mosi_n  = tx_data[TX_W-1];
        end
      end
      SH_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_n = 1'b1;
            rx_n  = {rx_q[6:0], miso};
          end else begin
            sck_n = 1'b0;
            if (bit_q == nb_q - 1'b1) begin
              st_n    = SH_GAP;
              cs_n_nx = 1'b1;
              gap_n   = 1'b0;
            end else begin
              bit_n  = bit_q + 1'b1;
              sreg_n = {sreg_q[TX_W-2:0], 1'b0};
              mosi_n = sreg_q[TX_W-2];
            end
          end
        end
      end
      SH_GAP: begin
        if (tick) begin
          if (gap_q) begin
            st_n = SH_IDLE;
            dn_n = 1'b1;
          end else begin
            gap_n = 1'b1;
          end
        end
      end
      default: st_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sreg_q <= '0;
      nb_q   <= '0;
      bit_q  <= '0;
      rx_q   <= '0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      gap_q  <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      sreg_q <= sreg_n;
      nb_q   <= nb_n;
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      cs_q   <= cs_n_nx;
      sck_q  <= sck_n;
      mosi_q <= mosi_n;
      gap_q  <= gap_n;
      dn_q   <= dn_n;
    end
  end

  assign run       = (st_q != SH_IDLE);
  assign cs_n      = cs_q;
  assign sck       = sck_q;
  assign mosi      = mosi_q;
  assign rx_byte   = rx_q;
  assign xfer_done = dn_q;

  AST_CS_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_q |-> !sck_q); // R9
  AST_MOSI_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n) (sck_q && $past(sck_q)) |-> $stable(mosi_q)); // R9
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_q) |=> cs_q); // R8
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == SH_SHIFT) |-> (bit_q < nb_q)); // R5
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bulk_sel,
  input  logic [23:0]       addr,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic              xfer_done,
  input  logic [7:0]        rx_byte,
  output logic              go,
  output logic [TX_W-1:0]   tx_data,
  output logic [NB_W-1:0]   nbits,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  c_state_t          st_q, st_n;
  logic              bulk_q, bulk_n;
  logic [23:0]       addr_q, addr_n;
  logic [POLL_W-1:0] lim_q, lim_n;
  logic [POLL_W-1:0] cnt_q, cnt_n;
  logic              done_q, done_n;
  logic              tmo_q, tmo_n;
  logic [POLL_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    st_n    = st_q;
    bulk_n  = bulk_q;
    addr_n  = addr_q;
    lim_n   = lim_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    tmo_n   = 1'b0;
    go      = 1'b0;
    tx_data = '0;
    nbits   = '0;
    case (st_q)
      C_IDLE: begin
        if (start) begin
          bulk_n  = bulk_sel;
          addr_n  = addr;
          lim_n   = poll_limit;
          go      = 1'b1;
          tx_data = {OP_WREN, 24'h0};
          nbits   = NB_W'(8);
          st_n    = C_WREN;
        end
      end
      C_WREN: begin
        if (xfer_done) begin
          go = 1'b1;
          if (bulk_q) begin
            tx_data = {OP_BULK, 24'h0};
            nbits   = NB_W'(8);
          end else begin
            tx_data = {OP_SECT, addr_q};
            nbits   = NB_W'(32);
          end
          st_n = C_ERASE;
        end
      end
      C_ERASE: begin
        if (xfer_done) begin
          go      = 1'b1;
          tx_data = {OP_RDSR, 24'h0};
          nbits   = NB_W'(16);
          cnt_n   = '0;
          st_n    = C_POLL;
        end
      end
      C_POLL: begin
        if (xfer_done) begin
          if (!rx_byte[WIP_BIT]) begin
            done_n = 1'b1;
            st_n   = C_IDLE;
          end else if (cnt_inc >= {1'b0, lim_q}) begin
            tmo_n = 1'b1;
            st_n  = C_IDLE;
          end else begin
            cnt_n   = cnt_inc[POLL_W-1:0];
            go      = 1'b1;
            tx_data = {OP_RDSR, 24'h0};
            nbits   = NB_W'(16);
          end
        end
      end
      default: st_n = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      bulk_q <= 1'b0;
      addr_q <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      bulk_q <= bulk_n;
      addr_q <= addr_n;
      lim_q  <= lim_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      tmo_q  <= tmo_n;
    end
  end

  assign busy    = (st_q != C_IDLE);
  assign done    = done_q;
  assign timeout = tmo_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R6
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_q && tmo_q)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> ($stable(addr_q) && $stable(bulk_q))); // R10
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (done_q || tmo_q) |-> !busy); // R6
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int POLL_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bulk_sel,
  input  logic [23:0]       addr,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  logic            rst_s;
  logic            run;
  logic            tick;
  logic            go;
  logic [TX_W-1:0] tx_data;
  logic [NB_W-1:0] nbits;
  logic [7:0]      rx_byte;
  logic            xfer_done;

  fes_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  fes_clk_div #(.HALF(CLK_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (run),
    .tick  (tick)
  );

  fes_shifter u_shf (
    .clk       (clk),
    .rst_n     (rst_s),
    .tick      (tick),
    .go        (go),
    .tx_data   (tx_data),
    .nbits     (nbits),
    .miso      (spi_miso),
    .run       (run),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte),
    .xfer_done (xfer_done)
  );

  fes_ctrl #(.POLL_W(POLL_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_s),
    .start      (start),
    .bulk_sel   (bulk_sel),
    .addr       (addr),
    .poll_limit (poll_limit),
    .xfer_done  (xfer_done),
    .rx_byte    (rx_byte),
    .go         (go),
    .tx_data    (tx_data),
    .nbits      (nbits),
    .busy       (busy),
    .done       (done),
    .timeout    (timeout)
  );
endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int PW         = 16;

  logic clk, rst_n, start, bulk_sel, spi_miso;
  logic [23:0] addr;
  logic [PW-1:0] poll_limit;
  logic spi_cs_n, spi_sck, spi_mosi, busy, done, timeout;

  flash_erase_seq #(.CLK_HALF(HALF), .POLL_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bulk_sel(bulk_sel), .addr(addr),
    .poll_limit(poll_limit), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .done(done),
    .timeout(timeout)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // flash model
  logic [31:0] shreg;
  int          rxc;
  int          remaining, busy_cfg;
  bit          wel;
  logic [7:0]  op_log [64];
  int          nb_log [64];
  logic [23:0] ad_log [64];
  int          ntx;

  function automatic logic [7:0] status_now();
    return {6'b0, wel, (remaining > 0)};
  endfunction

  always @(negedge spi_cs_n) begin
    rxc = 0; shreg = 0; spi_miso = 1'b0;
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    shreg = {shreg[30:0], spi_mosi}; rxc++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && rxc >= 8 && rxc < 16) begin
    logic [7:0] s;
    s = status_now();
    spi_miso = s[15 - rxc];
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    logic [7:0] op;
    op = (rxc == 32) ? shreg[31:24] : (rxc == 16) ? shreg[15:8] : shreg[7:0];
    if (ntx < 64) begin
      op_log[ntx] = op; nb_log[ntx] = rxc; ad_log[ntx] = shreg[23:0];
    end
    ntx++;
    if (op == 8'h06 && rxc == 8) wel = 1;
    else if (((op == 8'hD8 && rxc == 32) || (op == 8'hC7 && rxc == 8)) && wel) begin
      remaining = busy_cfg; wel = 0;
    end else if (op == 8'h05 && rxc == 16 && remaining > 0) remaining--;
  end

  // timing monitors sampled away from the active edge
  int gap_cnt, min_gap, hi_cnt, bad_hi, mode_bad;
  bit seen_tx, prev_sck, prev_mosi, prev_cs;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_cs_n) gap_cnt++;
      if (prev_cs && !spi_cs_n) begin
        if (seen_tx && gap_cnt < min_gap) min_gap = gap_cnt;
        seen_tx = 1;
      end
      if (!spi_cs_n) gap_cnt = 0;
      if (spi_sck) hi_cnt++;
      if (prev_sck && !spi_sck) begin
        if (hi_cnt != HALF) bad_hi++;
        hi_cnt = 0;
      end
      if (spi_cs_n && spi_sck) mode_bad++;
      if (!spi_cs_n && spi_sck && prev_sck && spi_mosi != prev_mosi) mode_bad++;
      prev_sck = spi_sck; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
    end
    if (cyc > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run(bit bulk, logic [23:0] a, int nbusy, int lim, bit poke);
    int lim_eff, exp_polls, done_hi, tmo_hi, waitc;
    bit exp_done;
    lim_eff   = (lim == 0) ? 1 : lim;
    exp_done  = (nbusy < lim_eff);
    exp_polls = exp_done ? nbusy + 1 : lim_eff;
    busy_cfg = nbusy; remaining = 0; wel = 0; ntx = 0;
    done_hi = 0; tmo_hi = 0;
    @(negedge clk);
    bulk_sel = bulk; addr = a; poll_limit = PW'(lim); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (7) @(negedge clk);
      bulk_sel = ~bulk; addr = ~a; poll_limit = 0; start = 1;
      @(negedge clk);
      start = 0;
    end
    waitc = 0;
    while (!(done || timeout) && waitc < 20000) begin @(negedge clk); waitc++; end
    while (waitc < 20000 && (done || timeout)) begin
      if (done) done_hi++;
      if (timeout) tmo_hi++;
      @(negedge clk); waitc++;
    end
    repeat (40) @(negedge clk);
    check("R6 done pulse count", done_hi, exp_done ? 1 : 0);
    check("R7 timeout pulse count", tmo_hi, exp_done ? 0 : 1);
    check("R6/R7 busy after end", busy, 0);
    check("R5/R7 transaction count", ntx, 2 + exp_polls);
    check("R2 wren opcode", op_log[0], 8'h06);
    check("R2 wren clocks", nb_log[0], 8);
    if (bulk) begin
      check("R4 bulk opcode", op_log[1], 8'hC7);
      check("R4 bulk clocks", nb_log[1], 8);
    end else begin
      check("R3 sector opcode", op_log[1], 8'hD8);
      check("R3 sector clocks", nb_log[1], 32);
      check("R3/R10 sector address", ad_log[1], a);
    end
    for (int i = 2; i < 2 + exp_polls && i < 64; i++) begin
      check("R5 poll opcode", op_log[i], 8'h05);
      check("R5 poll clocks", nb_log[i], 16);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; start = 0; bulk_sel = 0; addr = 0; poll_limit = 0;
    ntx = 0; wel = 0; remaining = 0; busy_cfg = 0; rxc = 0; shreg = 0; spi_miso = 0;
    gap_cnt = 0; min_gap = 1000000; hi_cnt = 0; bad_hi = 0; mode_bad = 0;
    seen_tx = 0; prev_sck = 0; prev_mosi = 0; prev_cs = 1;
    repeat (3) @(negedge clk);
    check("R1 cs_n reset", spi_cs_n, 1);
    check("R1 sck reset", spi_sck, 0);
    check("R1 busy/done/timeout reset", {busy, done, timeout}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 idle after release", {spi_cs_n, spi_sck, busy, done, timeout}, 5'b10000);

    run(0, 24'h01_2345, 0, 4, 0);
    run(1, 24'h00_0000, 3, 4, 0);
    run(0, 24'hFF_FFFF, 4, 4, 0);
    run(0, 24'h80_0001, 2, 0, 0);
    run(0, 24'hA5_5A3C, 2, 6, 1);
    run(1, 24'h12_3456, 1, 3, 1);
    for (int k = 0; k < 10; k++) begin
      bit b; logic [23:0] a; int nb, lm;
      b  = 1'($urandom_range(0, 1));
      a  = 24'($urandom);
      nb = $urandom_range(0, 6);
      lm = $urandom_range(0, 7);
      run(b, a, nb, lm, bit'($urandom_range(0, 1)));
    end

    check("R8 min cs_n high gap ok", (min_gap >= 2 * HALF), 1);
    check("R9 mode 0 violations", mode_bad, 0);
    check("R11 sck high phase errors", bad_hi, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule